// File: doc/BRIEF.md
# Secure S-box Table Lookup Unit

This execution unit forms s-box table addresses without letting key-dependent bytes pass through general-purpose registers. It has a bank of wide operand registers and a 32-bit staging register. A staging operation takes the top 32-bit word of a chosen operand register into the staging register. In the same step, that operand register shifts up by one word. A lookup operation adds the top byte of the staging register to a 32-bit base address. It then rotates the staging register by one byte, so four lookups walk through one staged word.

The table lives in a private scratchpad. The scratchpad is not cached and answers only inside a fixed address window. Each lookup returns the computed address and the table entry together, one clock after the operation. The latency is the same whether or not the address hits the window. A zeroize input wipes the staging register and every operand register.

Top module: `sbox_lookup_unit`

## Requirements
- R1: After reset, res_valid and res_err are 0, res_addr and res_data are 0, and the staging register and all operand registers hold zero.
- R2: Operation code 1 (write-reg) loads wr_data into the operand register selected by reg_sel. No other operand register changes.
- R3: Operation code 2 (stage) copies bits [127:96] of the selected operand register into the staging register. In the same step it shifts that operand register left by 32 bits and fills the low 32 bits with zeros.
- R4: Operation code 3 (lookup) forms the address base_addr + zero-extended staging bits [31:24]. A carry out of bit 31 is discarded. The address appears on res_addr at the clock edge that follows the operation.
- R5: A lookup rotates the staging register left by 8 bits. Successive lookups therefore index bytes [31:24], [23:16], [15:8] and [7:0] of the staged word, and the fifth lookup returns to the first byte.
- R6: For an address inside the window [WIN_BASE, WIN_BASE+TBL_DEPTH), res_data carries entry (address - WIN_BASE) of the scratchpad. It is marked by res_valid for exactly the one cycle after the lookup.
- R7: An address outside the window gives res_data 0 and res_err 1. This happens with the same one-cycle latency and the same res_valid pulse as an in-window lookup.
- R8: Operation code 4 (table-write) stores wr_data[31:0] at scratchpad entry (base_addr - WIN_BASE) when base_addr is inside the window. An out-of-window write changes no entry.
- R9: When zeroize is high, the next edge clears the staging register and all operand registers. Any operation presented in the same cycle is discarded and produces no result.
- R10: res_valid is 0 in every cycle not directly after an accepted lookup, and res_err is never 1 while res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zeroize | input | 1 | Wipe staging and operand registers |
| op_code | input | 3 | 0 none, 1 write-reg, 2 stage, 3 lookup, 4 table-write |
| reg_sel | input | 3 | Operand register selector |
| wr_data | input | 128 | Write data for operand register or table entry |
| base_addr | input | 32 | Table base for lookup, entry address for table-write |
| res_valid | output | 1 | Result present this cycle |
| res_err | output | 1 | Lookup address fell outside the window |
| res_addr | output | 32 | Computed lookup address |
| res_data | output | 32 | Scratchpad entry, zero on error |

## Verification
Zeroize and a stage or lookup operation can be presented in the same cycle. This is the collision the bench exercises on purpose. It raises zeroize while a stage of a loaded register or a lookup is on op_code. It then judges the outcome at the ports in three ways. res_valid must stay low. A following lookup must yield the bare base address, which shows the staging register is clear. Re-staging the same register must also give a zero index, which shows the operand register was wiped rather than shifted.

// File: rtl/sbox_lu_pkg.sv
package sbox_lu_pkg;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_WREG  = 3'd1,
      OP_STAGE = 3'd2,
      OP_LOOK  = 3'd3,
      OP_TWR   = 3'd4
   } lu_op_e;

   function automatic logic [31:0] rotl_byte(input logic [31:0] w);
      return {w[23:0], w[31:24]};
   endfunction

endpackage

// File: rtl/sbox_lu_bank.sv
module sbox_lu_bank #(
   parameter int NUM_REGS = 8,
   parameter int REG_W    = 128,
   parameter int WORD_W   = 32,
   localparam int SEL_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wipe,
   input  logic              wr_en,
   input  logic              shift_en,
   input  logic [SEL_W-1:0]  sel,
   input  logic [REG_W-1:0]  wr_data,
   output logic [WORD_W-1:0] top_word
);

   localparam int KEEP_W = REG_W - WORD_W;

   logic [REG_W-1:0] bank_q [NUM_REGS];

   if (REG_W <= WORD_W) begin : g_bad_width
      $error("operand register must be wider than the staging word");
   end
   if ((REG_W % WORD_W) != 0) begin : g_bad_ratio
      $error("operand width must be a multiple of the word width");
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_q[g] <= '0;
         end else if (wipe) begin
            bank_q[g] <= '0;
         end else if (wr_en && (sel == SEL_W'(g))) begin
            bank_q[g] <= wr_data;
         end else if (shift_en && (sel == SEL_W'(g))) begin
            bank_q[g] <= {bank_q[g][KEEP_W-1:0], {WORD_W{1'b0}}};
         end
      end
   end

   always_comb begin
      top_word = bank_q[sel][REG_W-1 -: WORD_W];
   end

endmodule

// File: rtl/sbox_lu_stage.sv
module sbox_lu_stage #(
   parameter int WORD_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wipe,
   input  logic              load_en,
   input  logic              rot_en,
   input  logic [WORD_W-1:0] load_word,
   output logic [WORD_W-1:0] stage_q,
   output logic [IDX_W-1:0]  index
);

   if ((WORD_W % IDX_W) != 0) begin : g_bad_idx
      $error("staging word must hold a whole number of index bytes");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (wipe) begin
         stage_q <= '0;
      end else if (load_en) begin
         stage_q <= load_word;
      end else if (rot_en) begin
         stage_q <= {stage_q[WORD_W-IDX_W-1:0], stage_q[WORD_W-1 -: IDX_W]};
      end
   end

   assign index = stage_q[WORD_W-1 -: IDX_W];

endmodule

// File: rtl/sbox_lu_table.sv
module sbox_lu_table #(
   parameter int          WORD_W    = 32,
   parameter int          IDX_W     = 8,
   parameter int          TBL_DEPTH = 256,
   parameter logic [31:0] WIN_BASE  = 32'h0000_1000,
   localparam int         TA_W      = $clog2(TBL_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              look_en,
   input  logic              twr_en,
   input  logic [WORD_W-1:0] base_addr,
   input  logic [IDX_W-1:0]  index,
   input  logic [WORD_W-1:0] twr_data,
   output logic              res_valid,
   output logic              res_err,
   output logic [WORD_W-1:0] res_addr,
   output logic [WORD_W-1:0] res_data
);

   if ((1 << TA_W) != TBL_DEPTH) begin : g_bad_depth
      $error("table depth must be a power of two");
   end

   logic [WORD_W-1:0] mem [TBL_DEPTH];
   logic [WORD_W-1:0] look_addr, look_off, wr_off;
   logic              look_hit, wr_hit;

   always_comb begin
      look_addr = base_addr + {{(WORD_W-IDX_W){1'b0}}, index};
      look_off  = look_addr - WORD_W'(WIN_BASE);
      wr_off    = base_addr - WORD_W'(WIN_BASE);
      look_hit  = look_off < WORD_W'(TBL_DEPTH);
      wr_hit    = wr_off < WORD_W'(TBL_DEPTH);
   end

   always_ff @(posedge clk) begin
      if (twr_en && wr_hit) begin
         mem[wr_off[TA_W-1:0]] <= twr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_err   <= 1'b0;
         res_addr  <= '0;
         res_data  <= '0;
      end else begin
         res_valid <= look_en;
         res_err   <= look_en && !look_hit;
         if (look_en) begin
            res_addr <= look_addr;
            res_data <= look_hit ? mem[look_off[TA_W-1:0]] : '0;
         end
      end
   end

endmodule

// File: rtl/sbox_lookup_unit.sv
module sbox_lookup_unit
   import sbox_lu_pkg::*;
#(
   parameter int          NUM_REGS  = 8,
   parameter int          REG_W     = 128,
   parameter int          WORD_W    = 32,
   parameter int          IDX_W     = 8,
   parameter int          TBL_DEPTH = 256,
   parameter logic [31:0] WIN_BASE  = 32'h0000_1000,
   localparam int         SEL_W     = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              zeroize,
   input  logic [2:0]        op_code,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [WORD_W-1:0] base_addr,
   output logic              res_valid,
   output logic              res_err,
   output logic [WORD_W-1:0] res_addr,
   output logic [WORD_W-1:0] res_data
);

   lu_op_e            op;
   logic              do_wreg, do_stage, do_look, do_twr;
   logic [WORD_W-1:0] top_word, stage_q;
   logic [IDX_W-1:0]  index;

   always_comb begin
      op       = lu_op_e'(op_code);
      do_wreg  = !zeroize && (op == OP_WREG);
      do_stage = !zeroize && (op == OP_STAGE);
      do_look  = !zeroize && (op == OP_LOOK);
      do_twr   = !zeroize && (op == OP_TWR);
   end

   sbox_lu_bank #(
      .NUM_REGS(NUM_REGS), .REG_W(REG_W), .WORD_W(WORD_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wipe(zeroize),
      .wr_en(do_wreg), .shift_en(do_stage), .sel(reg_sel),
      .wr_data(wr_data), .top_word(top_word)
   );

   sbox_lu_stage #(
      .WORD_W(WORD_W), .IDX_W(IDX_W)
   ) u_stage (
      .clk(clk), .rst_n(rst_n), .wipe(zeroize),
      .load_en(do_stage), .rot_en(do_look), .load_word(top_word),
      .stage_q(stage_q), .index(index)
   );

   sbox_lu_table #(
      .WORD_W(WORD_W), .IDX_W(IDX_W), .TBL_DEPTH(TBL_DEPTH), .WIN_BASE(WIN_BASE)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .look_en(do_look), .twr_en(do_twr),
      .base_addr(base_addr), .index(index), .twr_data(wr_data[WORD_W-1:0]),
      .res_valid(res_valid), .res_err(res_err),
      .res_addr(res_addr), .res_data(res_data)
   );

endmodule

// File: rtl/sbox_lookup_checker.sv
module sbox_lookup_checker
   import sbox_lu_pkg::*;
#(
   parameter int          TBL_DEPTH = 256,
   parameter logic [31:0] WIN_BASE  = 32'h0000_1000
) (
   input logic        clk,
   input logic        rst_n,
   input logic        zeroize,
   input logic [2:0]  op_code,
   input logic [31:0] base_addr,
   input logic [31:0] stage_q,
   input logic        res_valid,
   input logic        res_err,
   input logic [31:0] res_addr,
   input logic [31:0] res_data
);

   logic look_req;
   assign look_req = !zeroize && (op_code == 3'd3);

   assert_valid_after_lookup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      look_req |=> res_valid);

   assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !look_req |=> !res_valid);

   assert_err_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> res_valid);

   assert_err_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> (res_data == 32'd0));

   assert_err_matches_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_err == ((res_addr - WIN_BASE) >= 32'(TBL_DEPTH))));

   assert_addr_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
      look_req |=> (res_addr == $past(base_addr) + {24'd0, $past(stage_q[31:24])}));

   assert_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      look_req |=> (stage_q == rotl_byte($past(stage_q))));

   assert_zeroize_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      zeroize |=> (stage_q == 32'd0));

endmodule

bind sbox_lookup_unit sbox_lookup_checker #(
   .TBL_DEPTH(TBL_DEPTH), .WIN_BASE(WIN_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .zeroize(zeroize), .op_code(op_code),
   .base_addr(base_addr), .stage_q(stage_q), .res_valid(res_valid),
   .res_err(res_err), .res_addr(res_addr), .res_data(res_data)
);

// File: tb/sbox_lookup_unit_bench.sv
module sbox_lookup_unit_bench;

   localparam logic [31:0] WB  = 32'h0000_1000;
   localparam int          DEP = 256;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         zeroize = 1'b0;
   logic [2:0]   op_code = 3'd0;
   logic [2:0]   reg_sel = 3'd0;
   logic [127:0] wr_data = '0;
   logic [31:0]  base_addr = '0;
   logic         res_valid, res_err;
   logic [31:0]  res_addr, res_data;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sbox_lookup_unit u_sbox_lookup_unit (
      .clk(clk), .rst_n(rst_n), .zeroize(zeroize), .op_code(op_code),
      .reg_sel(reg_sel), .wr_data(wr_data), .base_addr(base_addr),
      .res_valid(res_valid), .res_err(res_err),
      .res_addr(res_addr), .res_data(res_data)
   );

   function automatic logic [31:0] tval(input int i);
      logic [7:0] b;
      b = 8'(i);
      return {b ^ 8'h5A, b, ~b, 8'(i * 3)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at a falling edge; return at the next falling edge with results settled
   task automatic issue(input logic [2:0] op, input logic [2:0] sel,
                        input logic [127:0] d, input logic [31:0] b, input logic z);
      @(negedge clk);
      op_code = op; reg_sel = sel; wr_data = d; base_addr = b; zeroize = z;
      @(negedge clk);
      op_code = 3'd0; zeroize = 1'b0;
   endtask

   task automatic look_chk(input string tag, input logic [31:0] b, input logic [31:0] exp_addr);
      issue(3'd3, 3'd0, '0, b, 1'b0);
      chk({tag, " valid"}, {31'd0, res_valid}, 32'd1);
      chk({tag, " addr"}, res_addr, exp_addr);
      if ((exp_addr - WB) < DEP) begin
         chk({tag, " data"}, res_data, tval(int'(exp_addr - WB)));
         chk({tag, " err"}, {31'd0, res_err}, 32'd0);
      end else begin
         chk({tag, " data"}, res_data, 32'd0);
         chk({tag, " err"}, {31'd0, res_err}, 32'd1);
      end
   endtask

   task automatic t_reset;
      chk("R1 valid", {31'd0, res_valid}, 32'd0);
      chk("R1 err", {31'd0, res_err}, 32'd0);
      chk("R1 addr", res_addr, 32'd0);
      chk("R1 data", res_data, 32'd0);
   endtask

   task automatic t_fill;
      for (int i = 0; i < DEP; i++) issue(3'd4, 3'd0, {96'd0, tval(i)}, WB + 32'(i), 1'b0);
      look_chk("R1 zero staging", WB, WB);
      issue(3'd2, 3'd6, '0, '0, 1'b0);
      look_chk("R1 zero register", WB, WB);
   endtask

   task automatic t_walk;
      issue(3'd1, 3'd0, {32'hEE000000, 96'd0}, '0, 1'b0);
      issue(3'd1, 3'd3, 128'h11223344_55667788_99AABBCC_DDEEFF00, '0, 1'b0);
      issue(3'd2, 3'd3, '0, '0, 1'b0);
      look_chk("R2 R3 R4 byte3", WB, WB + 32'h11);
      look_chk("R5 byte2", WB, WB + 32'h22);
      look_chk("R5 byte1", WB, WB + 32'h33);
      look_chk("R5 byte0", WB, WB + 32'h44);
      look_chk("R5 wraps to byte3", WB, WB + 32'h11);
      chk("R10 idle", {31'd0, res_valid}, 32'd1);
      @(negedge clk);
      chk("R10 no lookup", {31'd0, res_valid}, 32'd0);
      chk("R10 no err", {31'd0, res_err}, 32'd0);
      issue(3'd2, 3'd3, '0, '0, 1'b0);
      look_chk("R3 second word", WB, WB + 32'h55);
      issue(3'd2, 3'd3, '0, '0, 1'b0);
      look_chk("R3 third word", WB, WB + 32'h99);
      issue(3'd2, 3'd3, '0, '0, 1'b0);
      look_chk("R3 fourth word", WB, WB + 32'hDD);
      issue(3'd2, 3'd3, '0, '0, 1'b0);
      look_chk("R3 zero fill", WB, WB);
      issue(3'd2, 3'd0, '0, '0, 1'b0);
      look_chk("R2 other reg intact", WB, WB + 32'hEE);
   endtask

   task automatic t_window;
      issue(3'd1, 3'd4, {32'h20FA0500, 96'd0}, '0, 1'b0);
      issue(3'd2, 3'd4, '0, '0, 1'b0);
      look_chk("R4 R7 carry dropped", 32'hFFFF_FFF0, 32'h0000_0010);
      look_chk("R7 above window", WB + 32'd10, WB + 32'd10 + 32'hFA);
      issue(3'd4, 3'd0, {96'd0, 32'hDEADBEEF}, WB + 32'(DEP) + 32'd5, 1'b0);
      look_chk("R8 out-of-window write ignored", WB, WB + 32'd5);
      look_chk("R6 last entry", WB + 32'(DEP - 1), WB + 32'(DEP - 1));
   endtask

   task automatic t_zeroize;
      issue(3'd1, 3'd1, {32'h77665544, 96'd1}, '0, 1'b0);
      issue(3'd2, 3'd1, '0, '0, 1'b0);
      issue(3'd0, 3'd0, '0, '0, 1'b1);
      look_chk("R9 staging wiped", WB, WB);
      issue(3'd2, 3'd1, '0, '0, 1'b0);
      look_chk("R9 register wiped", WB, WB);
      issue(3'd1, 3'd2, {32'hAB000000, 96'd7}, '0, 1'b0);
      issue(3'd2, 3'd2, '0, '0, 1'b1);
      look_chk("R9 stage dropped", WB, WB);
      issue(3'd2, 3'd2, '0, '0, 1'b0);
      look_chk("R9 register not shifted but wiped", WB, WB);
      issue(3'd3, 3'd0, '0, WB, 1'b1);
      chk("R9 lookup dropped", {31'd0, res_valid}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill();
      t_walk();
      t_window();
      t_zeroize();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5 * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule